// File: doc/BRIEF.md
# Configuration Word Checksum Checker

This block checks the integrity of a block of 16-bit configuration words as an upstream non-volatile memory reader delivers them. Each accepted word that is not marked as the final word of its block is added into a wide running sum. The word marked as final is the stored checksum. It is not added. Instead it is compared with the low 16 bits of the running sum, and a one-cycle verdict is issued.

A block passes only when two conditions hold. The low 16 bits of the sum must equal the checksum word, and the full-width sum must not be zero. The second condition rejects a block that reads back as all zeros, such as a blank or absent memory, even though its low bits would match. The sum clears when a verdict is produced, so one block can follow another with no idle cycle between them.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after the input rises.

Top module: `cfgsum_checker`

## Requirements
- R1: While reset is held, `res_valid` and `res_pass` are 0. After reset the running sum is zero, so a block that was only partly delivered before reset does not affect the next block.
- R2: Each accepted word (`in_valid`=1) with `in_last`=0 is added into a 32-bit sum. Carries out of bit 15 are kept, so the sum is not truncated while it builds up.
- R3: The word accepted with `in_last`=1 is the checksum word. It is not added to the sum, and it is compared with bits 15:0 of the sum of the words before it.
- R4: When bits 15:0 of the sum differ from the checksum word, the verdict is a failure (`res_pass`=0).
- R5: When the full 32-bit sum is exactly zero, the verdict is a failure even if the checksum word is also zero.
- R6: `res_valid` is high for exactly one cycle, in the cycle after a word with `in_last`=1 is accepted. `res_pass` is 0 whenever `res_valid` is 0.
- R7: The sum clears when the checksum word is accepted. A word accepted in the very next cycle starts a new block.
- R8: A block made of a single word with `in_last`=1 has a zero sum and is reported as a failure.
- R9: When `in_valid`=0, `in_word` and `in_last` are ignored. The sum is unchanged and no verdict is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_word | input | 16 | Configuration word, or checksum word when `in_last` is 1 |
| in_valid | input | 1 | Accept strobe for `in_word` and `in_last` |
| in_last | input | 1 | Marks the accepted word as the checksum word that ends the block |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_pass | output | 1 | Verdict: 1 = block intact; 0 whenever `res_valid` is 0 |

## Verification
The first block has a correct checksum, and would fail if the checksum word were wrongly added to the sum. A block whose sum is exactly 0x10000 passes only if carries beyond bit 15 are kept. An all-zero block and a lone checksum word separate the zero-sum rejection from an ordinary mismatch. Idle cycles carry an active-looking `in_last` and junk data to show that unaccepted inputs have no effect. Back-to-back blocks and a reset in the middle of a block show that the sum is cleared between blocks.

// File: rtl/cfgsum_pkg.sv
package cfgsum_pkg;

  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_ACC_W  = 32;

  typedef struct packed {
    logic valid;
    logic pass;
  } verdict_t;

endpackage

// File: rtl/cfgsum_rst_sync.sv
module cfgsum_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/cfgsum_accum.sv
module cfgsum_accum #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last,
  input  logic [WORD_W-1:0] word,
  output logic [ACC_W-1:0]  sum
);

  localparam int unsigned PAD_W = ACC_W - WORD_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;
  logic [ACC_W-1:0] word_ext;

  assign word_ext = {{PAD_W{1'b0}}, word};

  always_comb begin
    acc_en = take;
    acc_d  = acc_q;
    if (take) begin
      if (last) acc_d = '0;
      else      acc_d = acc_q + word_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign sum = acc_q;

  // R7: the sum is empty once a checksum word has been taken
  p_clear_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> (acc_q == '0));

  // R9: nothing moves the sum while no word is accepted
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(acc_q));

  // R2: a nonzero data word always changes the sum
  p_data_moves_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !last && (word != '0)) |=> (acc_q != $past(acc_q)));

endmodule

// File: rtl/cfgsum_judge.sv
module cfgsum_judge
  import cfgsum_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last,
  input  logic [WORD_W-1:0] word,
  input  logic [ACC_W-1:0]  sum,
  output logic              res_valid,
  output logic              res_pass
);

  verdict_t verdict_q;
  verdict_t verdict_d;
  logic     low_match;
  logic     sum_nonzero;

  assign low_match   = (sum[WORD_W-1:0] == word);
  assign sum_nonzero = (sum != '0);

  always_comb begin
    verdict_d.valid = take && last;
    verdict_d.pass  = take && last && low_match && sum_nonzero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_q <= '0;
    else        verdict_q <= verdict_d;
  end

  assign res_valid = verdict_q.valid;
  assign res_pass  = verdict_q.pass;

  // R5: an all-zero sum is rejected
  p_zero_sum_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last && (sum == '0)) |=> (res_valid && !res_pass));

  // R4: a low-half mismatch is rejected
  p_mismatch_rejected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last && (sum[WORD_W-1:0] != word)) |=> (res_valid && !res_pass));

  // R6: a pass is only ever reported together with the strobe
  p_pass_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_pass |-> res_valid);

endmodule

// File: rtl/cfgsum_checker.sv
module cfgsum_checker
  import cfgsum_pkg::*;
#(
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned ACC_W      = DEF_ACC_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              res_valid,
  output logic              res_pass
);

  logic             rst_q;
  logic [ACC_W-1:0] run_sum;

  cfgsum_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  cfgsum_accum #(
    .WORD_W (WORD_W),
    .ACC_W  (ACC_W)
  ) accum_i (
    .clk   (clk),
    .rst_n (rst_q),
    .take  (in_valid),
    .last  (in_last),
    .word  (in_word),
    .sum   (run_sum)
  );

  cfgsum_judge #(
    .WORD_W (WORD_W),
    .ACC_W  (ACC_W)
  ) judge_i (
    .clk       (clk),
    .rst_n     (rst_q),
    .take      (in_valid),
    .last      (in_last),
    .word      (in_word),
    .sum       (run_sum),
    .res_valid (res_valid),
    .res_pass  (res_pass)
  );

  // R6: the strobe follows an accepted checksum word by exactly one cycle
  p_valid_after_last_r6: assert property (@(posedge clk) disable iff (!rst_q)
    res_valid == $past(in_valid && in_last));

  // R1: outputs are quiet while reset is held
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_q |-> (!res_valid && !res_pass));

endmodule

// File: tb/cfgsum_checker_tb_top.sv
module cfgsum_checker_tb_top;

  localparam int NVEC = 22;

  logic        clk;
  logic        rst_n;
  logic [15:0] in_word;
  logic        in_valid;
  logic        in_last;
  logic        res_valid;
  logic        res_pass;

  int  n_checks;
  int  n_errors;
  bit  finished;

  // vector: {valid, last, word[15:0], expected pass}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 16'h1234, 1'b0},
    {1'b1, 1'b0, 16'h0101, 1'b0},
    {1'b1, 1'b1, 16'h1335, 1'b1},  // R3 correct checksum, not self-added
    {1'b1, 1'b0, 16'h0001, 1'b0},
    {1'b1, 1'b1, 16'h0002, 1'b0},  // R4 mismatch
    {1'b0, 1'b1, 16'hFFFF, 1'b0},  // R9 idle with junk
    {1'b1, 1'b0, 16'h8000, 1'b0},
    {1'b0, 1'b0, 16'h7777, 1'b0},  // R9 idle with junk
    {1'b1, 1'b0, 16'h8000, 1'b0},
    {1'b1, 1'b1, 16'h0000, 1'b1},  // R2 sum 0x10000 keeps carry
    {1'b1, 1'b1, 16'h0000, 1'b0},  // R8 lone checksum word
    {1'b1, 1'b0, 16'h0000, 1'b0},
    {1'b1, 1'b0, 16'h0000, 1'b0},
    {1'b1, 1'b1, 16'h0000, 1'b0},  // R5 all-zero block
    {1'b1, 1'b0, 16'hFFFF, 1'b0},
    {1'b1, 1'b0, 16'hFFFF, 1'b0},
    {1'b1, 1'b1, 16'hFFFE, 1'b1},
    {1'b1, 1'b0, 16'h0005, 1'b0},
    {1'b1, 1'b1, 16'h0005, 1'b1},  // R7 back-to-back, sum cleared
    {1'b1, 1'b0, 16'h00FF, 1'b0},
    {1'b1, 1'b1, 16'h01FF, 1'b0},  // R4 mismatch in upper byte
    {1'b0, 1'b0, 16'h0000, 1'b0}
  };

  cfgsum_checker dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_word   (in_word),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .res_valid (res_valid),
    .res_pass  (res_pass)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic l, input logic [15:0] w);
    @(negedge clk);
    in_valid = v;
    in_last  = l;
    in_word  = w;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    finished = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_word  = '0;

    // R1: quiet while reset held, even with a checksum word presented
    repeat (2) @(negedge clk);
    in_valid = 1'b1; in_last = 1'b1; in_word = 16'h0000;
    @(posedge clk); #2;
    check("R1 valid in reset", res_valid, 1'b0);
    check("R1 pass in reset", res_pass, 1'b0);
    drive(1'b0, 1'b0, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][18], VEC[i][17], VEC[i][16:1]);
      @(posedge clk); #2;
      check("R6 valid strobe", res_valid, VEC[i][18] & VEC[i][17]);
      check("R3/R4/R5/R7 verdict", res_pass, VEC[i][0]);
    end

    // R6: strobe lasts one cycle only
    drive(1'b1, 1'b0, 16'h0009);
    drive(1'b1, 1'b1, 16'h0009);
    @(posedge clk); #2;
    check("R6 strobe high", res_valid, 1'b1);
    check("R6 pass", res_pass, 1'b1);
    drive(1'b0, 1'b0, 16'h0000);
    @(posedge clk); #2;
    check("R6 strobe drops", res_valid, 1'b0);
    check("R6 pass drops", res_pass, 1'b0);

    // R1: reset in mid-block discards partial sum
    drive(1'b1, 1'b0, 16'h0007);
    drive(1'b0, 1'b0, 16'h0000);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b1, 1'b0, 16'h0003);
    drive(1'b1, 1'b1, 16'h0003);
    @(posedge clk); #2;
    check("R1 valid after mid reset", res_valid, 1'b1);
    check("R1 sum cleared by reset", res_pass, 1'b1);
    drive(1'b0, 1'b0, 16'h0000);
    @(negedge clk);

    finish_run();
  end

endmodule